// File: doc/BRIEF.md
# Four-Digit Multiplexed Seven-Segment Voltage Display Driver

This block turns a raw 12-bit converter reading into a four-digit millivolt readout on a multiplexed seven-segment display. The reading is scaled against a 2.5 V full scale: the shown value is the integer part of sample × 2500 / 4096. That value is split into thousands, hundreds, tens and units. The four digits share one active-low segment bus, and each digit has its own active-low enable. The segment patterns are for common-anode displays.

The scan goes through the digits in a fixed order. Each digit slot starts with a blanking gap, in which every enable is high and the segments are dark. The digit is then lit for a dwell time set by a parameter and counted in clock cycles. A new reading can arrive at any time. The block captures it at once, but it reaches the display only at the boundary between two complete scans, so no scan ever mixes the digits of two readings.

Top module: `sevenseg_scan`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all digit enables are high and the segment bus is 8'hFF.
- R2: The shown value is floor(sample × 2500 / 4096) millivolts, where sample is the last reading committed to the display. Before any reading has been committed, the shown value is 0.
- R3: Slot 0 drives digitN[0] low and shows the thousands digit. Slot 1 drives digitN[1] and shows hundreds. Slot 2 drives digitN[2] and shows tens. Slot 3 drives digitN[3] and shows units. The scan runs through slots 0, 1, 2, 3 and then wraps back to 0.
- R4: While a digit is lit, segN carries that digit's active-low code. Digits 0 to 9 map to hex C0, F9, A4, B0, 99, 92, 82, F8, 80, 90.
- R5: No more than one digit enable is low in any cycle.
- R6: Every slot begins with BLANK_CYCLES cycles in which all enables are high and segN is FF. An enable is therefore always released before the next digit's code appears.
- R7: After its blanking gap, each digit is lit for exactly DWELL_CYCLES cycles. While it is lit, its segment code does not change.
- R8: A reading accepted while a scan is in progress reaches the display only at the start of the next scan.
- R9: If several readings are accepted within one scan, the last one is the reading committed at the next scan boundary.
- R10: A reading accepted in the final cycle of a scan is committed at the end of the following scan. The reading that was pending before it is the one committed at the boundary where it arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Strobe: sampleIn holds a new reading this cycle |
| sampleIn | input | SAMPLE_W (12) | Raw converter reading |
| segN | output | 8 | Active-low segment bus, shared by all digits |
| digitN | output | NUM_DIGITS (4) | Active-low digit enables; bit 0 selects the thousands digit |

## Verification
The bench builds the driver with DWELL_CYCLES = 3 and BLANK_CYCLES = 2, so one full scan takes only 20 cycles. With scans that short, the bench can sweep about 800 readings across the whole 12-bit range and compare every output cycle of two scans per reading against arithmetic in the bench. The sweep includes 0, 4095 and the readings where decimal digits roll over. The short scan also makes it cheap to place readings at chosen cycles within a scan, including the last cycle and several within one scan, which is where the commit timing can go wrong.

// File: rtl/segscan_pkg.sv
package segscan_pkg;

  typedef struct packed {
    logic       commit;
    logic       lit;
    logic [1:0] slot;
  } scanCtl_t;

  function automatic logic [7:0] segCode(input logic [3:0] value);
    logic [7:0] code;
    case (value)
      4'd0:    code = 8'hC0;
      4'd1:    code = 8'hF9;
      4'd2:    code = 8'hA4;
      4'd3:    code = 8'hB0;
      4'd4:    code = 8'h99;
      4'd5:    code = 8'h92;
      4'd6:    code = 8'h82;
      4'd7:    code = 8'hF8;
      4'd8:    code = 8'h80;
      4'd9:    code = 8'h90;
      default: code = 8'hFF;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/scan_control.sv
module scan_control
  import segscan_pkg::*;
#(
  parameter int unsigned NUM_DIGITS   = 4,
  parameter int unsigned DWELL_CYCLES = 176000,
  parameter int unsigned BLANK_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rstN,
  output scanCtl_t ctl
);
  localparam int unsigned MAX_CNT   = (DWELL_CYCLES > BLANK_CYCLES) ? DWELL_CYCLES : BLANK_CYCLES;
  localparam int unsigned CNT_W     = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] DWELL_LAST = CNT_W'(DWELL_CYCLES - 1);
  localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(BLANK_CYCLES - 1);
  localparam logic [1:0]       LAST_SLOT  = 2'(NUM_DIGITS - 1);

  logic [CNT_W-1:0] phaseCnt;
  logic             litPhase;
  logic [1:0]       slotIdx;
  logic             dwellDone;
  logic             blankDone;

  assign dwellDone = litPhase && (phaseCnt == DWELL_LAST);
  assign blankDone = !litPhase && (phaseCnt == BLANK_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      litPhase <= 1'b0;
      slotIdx  <= '0;
    end else if (blankDone) begin
      phaseCnt <= '0;
      litPhase <= 1'b1;
    end else if (dwellDone) begin
      phaseCnt <= '0;
      litPhase <= 1'b0;
      slotIdx  <= (slotIdx == LAST_SLOT) ? 2'd0 : slotIdx + 2'd1;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.commit = dwellDone && (slotIdx == LAST_SLOT);
    ctl.lit    = litPhase;
    ctl.slot   = slotIdx;
  end

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import segscan_pkg::*;
#(
  parameter int unsigned SAMPLE_W      = 12,
  parameter int unsigned FULL_SCALE_MV = 2500,
  parameter int unsigned NUM_DIGITS    = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  scanCtl_t              ctl,
  input  logic                  sampleValid,
  input  logic [SAMPLE_W-1:0]   sampleIn,
  output logic [7:0]            segN,
  output logic [NUM_DIGITS-1:0] digitN
);
  localparam int unsigned MV_W   = $clog2(FULL_SCALE_MV + 1);
  localparam int unsigned PROD_W = SAMPLE_W + MV_W;

  logic [SAMPLE_W-1:0] pendSample;
  logic [MV_W-1:0]     shownMv;
  logic [PROD_W-1:0]   scaledProd;
  logic [3:0]          digitVal [NUM_DIGITS];

  assign scaledProd = PROD_W'(pendSample) * PROD_W'(FULL_SCALE_MV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendSample <= '0;
    end else if (sampleValid) begin
      pendSample <= sampleIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shownMv <= '0;
    end else if (ctl.commit) begin
      shownMv <= MV_W'(scaledProd >> SAMPLE_W);
    end
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : gDigit
    localparam int unsigned WEIGHT = 10 ** (NUM_DIGITS - 1 - g);
    logic [MV_W-1:0] quot;
    logic [MV_W-1:0] rem;
    assign quot        = shownMv / MV_W'(WEIGHT);
    assign rem         = quot % MV_W'(10);
    assign digitVal[g] = rem[3:0];
  end

  always_comb begin
    segN   = 8'hFF;
    digitN = '1;
    if (ctl.lit) begin
      digitN[ctl.slot] = 1'b0;
      segN             = segCode(digitVal[ctl.slot]);
    end
  end

endmodule

// File: rtl/sevenseg_scan.sv
module sevenseg_scan
  import segscan_pkg::*;
#(
  parameter int unsigned SAMPLE_W      = 12,
  parameter int unsigned FULL_SCALE_MV = 2500,
  parameter int unsigned NUM_DIGITS    = 4,
  parameter int unsigned DWELL_CYCLES  = 176000,
  parameter int unsigned BLANK_CYCLES  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleValid,
  input  logic [SAMPLE_W-1:0]   sampleIn,
  output logic [7:0]            segN,
  output logic [NUM_DIGITS-1:0] digitN
);
  scanCtl_t ctl;

  scan_control #(
    .NUM_DIGITS  (NUM_DIGITS),
    .DWELL_CYCLES(DWELL_CYCLES),
    .BLANK_CYCLES(BLANK_CYCLES)
  ) uControl (
    .clk (clk),
    .rstN(rstN),
    .ctl (ctl)
  );

  scan_datapath #(
    .SAMPLE_W     (SAMPLE_W),
    .FULL_SCALE_MV(FULL_SCALE_MV),
    .NUM_DIGITS   (NUM_DIGITS)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .sampleValid(sampleValid),
    .sampleIn   (sampleIn),
    .segN       (segN),
    .digitN     (digitN)
  );

endmodule

// File: rtl/sevenseg_scan_checker.sv
module sevenseg_scan_checker #(
  parameter int unsigned NUM_DIGITS = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [7:0]            segN,
  input logic [NUM_DIGITS-1:0] digitN
);

  assert_one_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~digitN));

  assert_dark_when_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (&digitN) |-> (segN == 8'hFF));

  assert_release_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!(&$past(digitN)) && (digitN != $past(digitN))) |-> (&digitN));

  assert_code_steady_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!(&digitN) && (digitN == $past(digitN))) |-> $stable(segN));

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_dark_R1: assert ((&digitN) && (segN == 8'hFF));
    end
  end

endmodule

bind sevenseg_scan sevenseg_scan_checker #(.NUM_DIGITS(NUM_DIGITS)) uChecker (
  .clk   (clk),
  .rstN  (rstN),
  .segN  (segN),
  .digitN(digitN)
);

// File: tb/tb_sevenseg_scan.sv
module tb_sevenseg_scan;
  localparam int DWELL    = 3;
  localparam int BLANK    = 2;
  localparam int SLOT_LEN = DWELL + BLANK;
  localparam int FRAME    = 4 * SLOT_LEN;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleIn = '0;
  logic [7:0]  segN;
  logic [3:0]  digitN;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sevenseg_scan #(
    .DWELL_CYCLES(DWELL),
    .BLANK_CYCLES(BLANK)
  ) dut (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .sampleIn   (sampleIn),
    .segN       (segN),
    .digitN     (digitN)
  );

  function automatic int toMv(input int s);
    return (s * 2500) / 4096;
  endfunction

  function automatic logic [7:0] expCode(input int d);
    case (d)
      0: return 8'hC0;
      1: return 8'hF9;
      2: return 8'hA4;
      3: return 8'hB0;
      4: return 8'h99;
      5: return 8'h92;
      6: return 8'h82;
      7: return 8'hF8;
      8: return 8'h80;
      default: return 8'h90;
    endcase
  endfunction

  task automatic check(input logic [3:0] expDig, input logic [7:0] expSeg, input string tag);
    total++;
    if (digitN !== expDig || segN !== expSeg) begin
      bad++;
      $display("FAIL %s: digitN=%b segN=%h expected digitN=%b segN=%h",
               tag, digitN, segN, expDig, expSeg);
    end
  endtask

  // Runs one scan from frame cycle 0, checking every cycle against expMv.
  // Optionally drives readings at cycles cA and cB (-1 means none).
  task automatic runFrame(input int expMv, input int cA, input int sA, input int cB, input int sB);
    for (int c = 0; c < FRAME; c++) begin
      int slot = c / SLOT_LEN;
      int inSlot = c % SLOT_LEN;
      if (inSlot < BLANK) begin
        check(4'hF, 8'hFF, "R6 blank gap");
      end else begin
        int w = (slot == 0) ? 1000 : (slot == 1) ? 100 : (slot == 2) ? 10 : 1;
        int d = (expMv / w) % 10;
        logic [3:0] en = ~(4'b0001 << slot);
        check(en, expCode(d), "R2/R3/R4/R5/R7 lit digit");
      end
      sampleValid = 1'b0;
      if (c == cA) begin sampleValid = 1'b1; sampleIn = 12'(sA); end
      if (c == cB) begin sampleValid = 1'b1; sampleIn = 12'(sB); end
      @(negedge clk);
    end
    sampleValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int prev;
    repeat (3) @(negedge clk);
    check(4'hF, 8'hFF, "R1 during reset");
    rstN = 1'b1;
    check(4'hF, 8'hFF, "R1 after release");
    // R2: zero shown before any reading
    runFrame(0, -1, 0, -1, 0);
    prev = 0;
    // R8 sweep: reading at cycle 0 not shown until next scan
    for (int s = 0; s < 4096; s += 5) begin
      runFrame(prev, 0, s, -1, 0);
      runFrame(toMv(s), -1, 0, -1, 0);
      prev = toMv(s);
    end
    runFrame(prev, 7, 4095, -1, 0);
    runFrame(toMv(4095), -1, 0, -1, 0);
    prev = toMv(4095);
    // R9: last of two readings in one scan wins
    runFrame(prev, 3, 1000, 12, 2049);
    runFrame(toMv(2049), -1, 0, -1, 0);
    prev = toMv(2049);
    // R10: reading in final scan cycle deferred by one scan
    runFrame(prev, FRAME - 1, 1639, -1, 0);
    runFrame(prev, -1, 0, -1, 0);
    runFrame(toMv(1639), -1, 0, -1, 0);
    prev = toMv(1639);
    // R8: reading mid-scan, then a reset returns to dark
    runFrame(prev, 9, 3277, -1, 0);
    runFrame(toMv(3277), -1, 0, -1, 0);
    rstN = 1'b0;
    @(negedge clk);
    check(4'hF, 8'hFF, "R1 re-reset");
    rstN = 1'b1;
    runFrame(0, -1, 0, -1, 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule